// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block sits between a serial receiver and the host. Every completed character arrives with its data byte and three per-character flags: parity error, framing error and break. The characters go into a three-entry first-in first-out queue. The host takes characters from the head of the queue through a valid/ready output stream. The block also produces a character-available flag, a queue-full flag and a sticky overrun flag. It reports the error flags in one of two ways, chosen by `blk_mode`. In per-character mode the flags belong only to the head entry. In accumulated mode they are the OR of every entry that has reached the head since the last error clear.

The receive side has no back-pressure. A character offered on `in_valid` is always taken in. When the queue is full, the character waits in a single holding slot, which stands in for the receiver's shift register. It moves into the queue in the same cycle that a pop frees an entry. If another character arrives while the holding slot is occupied and cannot drain, it overwrites the held character, the queue contents stay unchanged, and overrun is raised. On the output side, a pop happens on a clock edge where both `out_valid` and `out_ready` are high. `out_ready` has no effect while `out_valid` is low. Reading the status pins never pops anything.

Top module: `rx_fifo_status`

## Requirements
- R1: After reset, out_valid, fifo_full, overrun, st_perr, st_ferr and st_brk are all 0.
- R2: The queue holds at most three entries, and fifo_full is 1 exactly when three entries are stored.
- R3: out_valid is 1 exactly when at least one entry is stored. A character offered to an empty queue makes out_valid 1 after the next clock edge.
- R4: On a pop, out_data and out_perr/out_ferr/out_brk present the oldest entry, and entries leave in arrival order. out_ready while out_valid is 0 changes nothing.
- R5: With blk_mode=0, st_perr/st_ferr/st_brk equal the head entry's flags, and are 0 when the queue is empty. The flags appear in the same cycle that out_valid shows the entry.
- R6: With blk_mode=1, each status flag is the OR of the head entry's flag and the flags of every entry popped since the last clr_err.
- R7: A character that arrives while the queue is full and no pop occurs goes into the holding slot. A later pop moves it into the queue at the tail in that same cycle, so fifo_full stays 1.
- R8: A character that arrives while the holding slot is full and no pop occurs replaces the held character, leaves the queue unchanged, and sets overrun.
- R9: overrun and the accumulated flags stay set until clr_err. clr_err clears both, and it overrides a pop in the same cycle. A new overrun event in the clr_err cycle leaves overrun at 1. The current head entry still shows its own flags.
- R10: A pop in the same cycle as a transfer from the holding slot leaves the entry count unchanged. If a new character also arrives in that cycle, it takes the freed holding slot without raising overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receiver presents a completed character (always accepted) |
| in_data | input | DATA_W | Received data byte |
| in_perr | input | 1 | Parity error of the received character |
| in_ferr | input | 1 | Framing error of the received character |
| in_brk | input | 1 | Break flag of the received character |
| out_valid | output | 1 | At least one character is available (character-ready status) |
| out_ready | input | 1 | Host read; pops the head when out_valid is 1 |
| out_data | output | DATA_W | Head entry data |
| out_perr | output | 1 | Head entry parity error |
| out_ferr | output | 1 | Head entry framing error |
| out_brk | output | 1 | Head entry break flag |
| fifo_full | output | 1 | All three entries occupied |
| overrun | output | 1 | Sticky overrun flag |
| blk_mode | input | 1 | 0: per-character status, 1: accumulated status |
| clr_err | input | 1 | Clears overrun and accumulated flags |
| st_perr | output | 1 | Reported parity-error status |
| st_ferr | output | 1 | Reported framing-error status |
| st_brk | output | 1 | Reported break status |

## Verification
The bench fills the queue and pushes a fourth character into the holding slot. A design that dropped the held character, or wrote it over the head, would lose it or deliver the characters out of order at the pop. It then lands a pop and a new arrival in the same cycle while the holding slot is occupied. A design with bad count bookkeeping would drop fifo_full or raise a false overrun there. Accumulated mode is exercised across pops and clears, which catches status that only follows the head, or a clear that does not override a same-cycle pop. A long pseudo-random run compared every cycle against a queue-based model covers the interleavings of arrivals, reads and clears.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxf_flags_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  rxf_flags_t        wr_flags,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head_data,
  output rxf_flags_t        head_flags,
  output logic              full,
  output logic              empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_d [DEPTH];
  rxf_flags_t        mem_f [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // one write port per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wp == PW'(i)) begin
        mem_d[i] <= wr_data;
        mem_f[i] <= wr_flags;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= step_ptr(wp);
      if (rd_en) rp <= step_ptr(rp);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_data  = mem_d[rp];
  assign head_flags = mem_f[rp];
  assign full       = (cnt == CW'(DEPTH));
  assign empty      = (cnt == '0);
endmodule

// File: rtl/rxf_hold.sv
module rxf_hold
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  rxf_flags_t        in_flags,
  input  logic              q_full,
  input  logic              pop,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output rxf_flags_t        wr_flags,
  output logic              hold_v,
  output logic              ovr_evt
);
  logic [DATA_W-1:0] hold_d, nxt_d;
  rxf_flags_t        hold_f, nxt_f;
  logic              nxt_v, room;

  always_comb begin
    room     = !q_full || pop;
    wr_en    = 1'b0;
    wr_data  = in_data;
    wr_flags = in_flags;
    nxt_v    = hold_v;
    nxt_d    = hold_d;
    nxt_f    = hold_f;
    ovr_evt  = 1'b0;
    if (hold_v) begin
      if (room) begin
        wr_en    = 1'b1;
        wr_data  = hold_d;
        wr_flags = hold_f;
        nxt_v    = in_valid;
        nxt_d    = in_data;
        nxt_f    = in_flags;
      end else if (in_valid) begin
        nxt_d   = in_data;
        nxt_f   = in_flags;
        ovr_evt = 1'b1;
      end
    end else if (in_valid) begin
      if (room) begin
        wr_en = 1'b1;
      end else begin
        nxt_v = 1'b1;
        nxt_d = in_data;
        nxt_f = in_flags;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      hold_f <= '0;
    end else begin
      hold_v <= nxt_v;
      hold_d <= nxt_d;
      hold_f <= nxt_f;
    end
  end
endmodule

// File: rtl/rxf_errstat.sv
module rxf_errstat
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_mode,
  input  logic       clr_err,
  input  logic       pop,
  input  logic       head_valid,
  input  rxf_flags_t head_flags,
  input  logic       ovr_evt,
  output rxf_flags_t status,
  output logic       overrun
);
  rxf_flags_t acc, head_masked;

  assign head_masked = head_valid ? head_flags : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      overrun <= 1'b0;
    end else begin
      if (clr_err)  acc <= '0;
      else if (pop) acc <= acc | head_flags;
      if (ovr_evt)      overrun <= 1'b1;
      else if (clr_err) overrun <= 1'b0;
    end
  end

  assign status = blk_mode ? (acc | head_masked) : head_masked;
endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              in_brk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr,
  output logic              out_brk,
  output logic              fifo_full,
  output logic              overrun,
  input  logic              blk_mode,
  input  logic              clr_err,
  output logic              st_perr,
  output logic              st_ferr,
  output logic              st_brk
);
  rxf_flags_t        in_flags, wr_flags, head_flags, status;
  logic [DATA_W-1:0] wr_data;
  logic              wr_en, pop, q_full, q_empty, hold_v, ovr_evt;

  assign in_flags = '{brk: in_brk, ferr: in_ferr, perr: in_perr};
  assign pop      = out_ready && !q_empty;

  rxf_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_flags(in_flags),
    .q_full(q_full), .pop(pop),
    .wr_en(wr_en), .wr_data(wr_data), .wr_flags(wr_flags),
    .hold_v(hold_v), .ovr_evt(ovr_evt)
  );

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .wr_flags(wr_flags),
    .rd_en(pop),
    .head_data(out_data), .head_flags(head_flags),
    .full(q_full), .empty(q_empty)
  );

  rxf_errstat u_err (
    .clk(clk), .rst_n(rst_n),
    .blk_mode(blk_mode), .clr_err(clr_err), .pop(pop),
    .head_valid(!q_empty), .head_flags(head_flags),
    .ovr_evt(ovr_evt),
    .status(status), .overrun(overrun)
  );

  assign out_valid = !q_empty;
  assign fifo_full = q_full;
  assign out_perr  = head_flags.perr;
  assign out_ferr  = head_flags.ferr;
  assign out_brk   = head_flags.brk;
  assign st_perr   = status.perr;
  assign st_ferr   = status.ferr;
  assign st_brk    = status.brk;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid,
  input logic out_ready,
  input logic fifo_full,
  input logic overrun,
  input logic blk_mode,
  input logic clr_err,
  input logic st_perr,
  input logic st_ferr,
  input logic st_brk,
  input logic hold_v
);
  assert_full_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> out_valid);

  assert_idle_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);

  assert_empty_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && !out_valid) |-> !(st_perr || st_ferr || st_brk));

  assert_blk_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && st_ferr && !clr_err) |=> (!blk_mode || st_ferr));

  assert_hold_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> fifo_full);

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hold_v && !out_ready) |=> overrun);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_err) |=> overrun);

  assert_swap_keeps_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && out_ready) |=> fifo_full);
endmodule

bind rx_fifo_status rxf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .fifo_full(fifo_full), .overrun(overrun),
  .blk_mode(blk_mode), .clr_err(clr_err), .st_perr(st_perr),
  .st_ferr(st_ferr), .st_brk(st_brk), .hold_v(hold_v)
);

// File: tb/rx_fifo_status_test.sv
`timescale 1ns/1ps
module rx_fifo_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0, in_brk = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b0, blk_mode = 1'b0, clr_err = 1'b0;
  logic out_valid, out_perr, out_ferr, out_brk, fifo_full, overrun;
  logic st_perr, st_ferr, st_brk;
  logic [7:0] out_data;

  int tests = 0, fails = 0;
  bit model_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  rx_fifo_status uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_perr(in_perr), .in_ferr(in_ferr), .in_brk(in_brk),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk),
    .fifo_full(fifo_full), .overrun(overrun), .blk_mode(blk_mode),
    .clr_err(clr_err), .st_perr(st_perr), .st_ferr(st_ferr), .st_brk(st_brk)
  );

  // reference model: entry = {brk, ferr, perr, data}
  logic [10:0] q[$];
  logic [10:0] m_hold = '0;
  bit          m_hv = 1'b0, m_ovr = 1'b0;
  logic [2:0]  m_acc = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_hv = 0; m_ovr = 0; m_acc = '0;
    end else begin
      automatic bit pop = out_ready && q.size() > 0;
      automatic bit room = q.size() < 3 || pop;
      automatic logic [10:0] inc = {in_brk, in_ferr, in_perr, in_data};
      if (clr_err) m_acc = '0;
      else if (pop) m_acc = m_acc | q[0][10:8];
      if (clr_err) m_ovr = 0;
      if (pop) void'(q.pop_front());
      if (m_hv) begin
        if (room) begin
          q.push_back(m_hold);
          m_hv = in_valid;
          if (in_valid) m_hold = inc;
        end else if (in_valid) begin
          m_hold = inc; m_ovr = 1;
        end
      end else if (in_valid) begin
        if (room) q.push_back(inc);
        else begin m_hold = inc; m_hv = 1; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // full comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      automatic logic [2:0] hf = (q.size() > 0) ? q[0][10:8] : 3'b000;
      automatic logic [2:0] ex = blk_mode ? (m_acc | hf) : hf;
      chk("R3 out_valid", out_valid, q.size() > 0);
      chk("R2 fifo_full", fifo_full, q.size() == 3);
      chk("R8 overrun", overrun, m_ovr);
      if (q.size() > 0) begin
        chk("R4 out_data", out_data, q[0][7:0]);
        chk("R4 out_flags", {out_brk, out_ferr, out_perr}, q[0][10:8]);
      end
      chk(blk_mode ? "R6 status" : "R5 status", {st_brk, st_ferr, st_perr}, ex);
    end
  end

  task automatic step(input bit iv, input logic [7:0] d, input logic [2:0] fl,
                      input bit rd, input bit clr);
    in_valid = iv; in_data = d; {in_brk, in_ferr, in_perr} = fl;
    out_ready = rd; clr_err = clr;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 8'h00, 3'b000, 0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 fifo_full", fifo_full, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 status", {st_brk, st_ferr, st_perr}, 3'b000);
    model_on = 1'b1;

    // idle read on empty queue
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R4 idle read", out_valid, 0);

    // first character, parity error
    step(1, 8'hA1, 3'b001, 0, 0);
    chk("R3 ready after write", out_valid, 1);
    chk("R5 flags with ready", st_perr, 1);
    step(1, 8'hB2, 3'b000, 0, 0);
    step(1, 8'hC3, 3'b010, 0, 0);
    chk("R2 full at three", fifo_full, 1);
    step(1, 8'hD4, 3'b100, 0, 0);            // goes to holding slot
    chk("R7 held not overrun", overrun, 0);
    chk("R7 head unchanged", out_data, 8'hA1);
    step(0, 8'h00, 3'b000, 1, 0);            // pop A1, D4 moves in
    chk("R7 still full after pop", fifo_full, 1);
    chk("R7 next head", out_data, 8'hB2);
    step(1, 8'hE5, 3'b000, 0, 0);            // hold E5
    step(1, 8'hF6, 3'b000, 0, 0);            // overwrite with F6
    chk("R8 overrun set", overrun, 1);
    chk("R8 queue unchanged", out_data, 8'hB2);
    step(1, 8'h17, 3'b000, 1, 0);            // pop B2, F6 in, 17 held
    chk("R10 full kept", fifo_full, 1);
    chk("R10 head", out_data, 8'hC3);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R7 order D4", out_data, 8'hD4);
    chk("R5 brk of head", st_brk, 1);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R8 overwritten value", out_data, 8'hF6);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R10 tail from hold", out_data, 8'h17);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R3 drained", out_valid, 0);
    chk("R9 overrun sticky", overrun, 1);
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R9 overrun cleared", overrun, 0);

    // accumulated mode
    blk_mode = 1'b1;
    step(1, 8'h21, 3'b010, 0, 0);
    step(1, 8'h22, 3'b000, 0, 0);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R6 ferr kept after pop", st_ferr, 1);
    chk("R6 head clean", out_ferr, 0);
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R9 accumulation cleared", st_ferr, 0);
    step(0, 8'h00, 3'b000, 1, 0);
    idle();

    // pseudo-random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) blk_mode = $urandom_range(0, 1);
      step($urandom_range(0, 99) < 45, 8'($urandom), 3'($urandom),
           $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 4);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule